// File: doc/BRIEF.md
# Descriptor-Chained XOR / Copy / Fill Engine

A single-channel data mover with three operations. In XOR and copy operation it walks a chain of descriptors held in memory. Each descriptor names up to eight source buffers, one destination, a byte count and a link to the next descriptor. In XOR operation the engine combines the enabled sources word by word into the destination. In copy operation it moves source 0 to the destination. In fill operation no descriptor is used: destination, length and a 64-bit pattern come straight from registers.

Software programs a small register file: operation select, activation, head-of-chain pointer, a read-only current-descriptor pointer, fill destination, fill length and the two pattern halves. It then sets the start bit. When a descriptor finishes, the engine hands it back to software by rewriting its status word, then follows the link. A zero link parks the channel and produces a one-cycle end-of-chain pulse. Descriptor fetch, source reads, destination writes and status write-back all share one word-wide memory port. That port accesses one word per cycle, and read data is returned in the same cycle as the address.

Top module: `xdma_chain`

## Requirements
- R1: Register 0 (config) stores and reads back the whole 32-bit written word. Bits [2:0] select the operation: 3'b001 XOR, 3'b010 copy, 3'b100 fill. Any other value makes a start request do nothing.
- R2: Writing a word with bit 0 set to register 1 (activation) starts the idle channel. Reading register 1 returns bits [5:4] = 2'b01 while active and 2'b00 when idle, with all other bits 0. The channel goes active only after such a write.
- R3: A descriptor is 13 words at consecutive byte addresses:
  - word 0: status
  - word 1: command
  - word 2: byte count, bits [15:0]
  - word 3: next-descriptor byte address
  - word 4: destination byte address
  - words 5..12: source 0..7 byte addresses

  A start in XOR or copy operation fetches the descriptor at the address in register 2. A start is ignored when register 2 is zero.
- R4: In XOR operation, destination word w is the XOR of word w of every source i whose command bit i is set. With no source enabled, destination words are written as zero.
- R5: In copy operation, destination word w equals source 0 word w, whatever the command source-enable bits are.
- R6: The byte count is rounded up to whole 32-bit words. Destination words beyond that count are left unchanged.
- R7: On completing a descriptor the engine writes its status word with bit 31 cleared: 32'h0 normally, 32'h1 when the byte count is zero. A zero byte count writes no destination word.
- R8: A descriptor whose command bit 31 is clear writes no destination word. Its status is still written to 32'h0 and its next link is still followed.
- R9: The engine follows each nonzero next link. After the descriptor with a zero link, or at the end of a fill, it goes idle and pulses eoc_o high for exactly one cycle.
- R10: Register 3 reads the byte address of the descriptor being processed, or of the last descriptor finished.
- R11: Once idle, the engine does not process a descriptor linked in memory onto the finished tail until it is started again. A restart begins at the address in register 2.
- R12: In fill operation the engine writes a number of words equal to register 5's byte count rounded up. It starts at the byte address in register 4. Word k receives register 6 if k is even and register 7 if k is odd. No descriptor is read. A zero length goes idle at once with an eoc_o pulse and no writes.
- R13: mem_we_o is only asserted together with mem_req_o, and the memory port is used only while the channel is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index (0 config, 1 activation, 2 next, 3 current, 4 fill destination, 5 fill length, 6 pattern low, 7 pattern high) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on reg_addr_i |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data for the address presented in the same cycle |
| eoc_o | output | 1 | One-cycle pulse on returning to idle |

## Verification
The bench builds the block with its defaults: eight sources and a 16-bit byte count. With those values every one of the 256 source-enable combinations can be swept. Each mask is paired with byte counts from 1 to 12, which exercises the rounding to 1, 2 and 3 words and the untouched word after the last one. A mixed chain covers the copy path that ignores enable bits, a descriptor without its valid bit and a zero-count descriptor. Further tests relink a tail while the channel is idle and sweep fill lengths 0 to 9 bytes across both pattern halves.

// File: rtl/xdma_pkg.sv
package xdma_pkg;
  localparam int WORD_W = 32;

  // descriptor word offsets (hardware walks them in this order)
  localparam int OFF_STAT = 0;
  localparam int OFF_CMD  = 1;
  localparam int OFF_CNT  = 2;
  localparam int OFF_NEXT = 3;
  localparam int OFF_DEST = 4;
  localparam int OFF_SRC0 = 5;

  localparam int CMD_VALID_BIT = 31;
  localparam int ACT_GO_BIT    = 0;

  localparam int RA_W = 3;
  localparam logic [RA_W-1:0] RA_CFG  = 3'd0;
  localparam logic [RA_W-1:0] RA_ACT  = 3'd1;
  localparam logic [RA_W-1:0] RA_NEXT = 3'd2;
  localparam logic [RA_W-1:0] RA_CUR  = 3'd3;
  localparam logic [RA_W-1:0] RA_DST  = 3'd4;
  localparam logic [RA_W-1:0] RA_SIZE = 3'd5;
  localparam logic [RA_W-1:0] RA_PLO  = 3'd6;
  localparam logic [RA_W-1:0] RA_PHI  = 3'd7;

  localparam logic [2:0] MODE_XOR  = 3'b001;
  localparam logic [2:0] MODE_COPY = 3'b010;
  localparam logic [2:0] MODE_FILL = 3'b100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_PREP, ST_SRC, ST_WR, ST_STAT, ST_FILL
  } state_e;
endpackage

// File: rtl/xdma_regs.sv
module xdma_regs
  import xdma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RA_W-1:0]   addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic [WORD_W-1:0] cur_desc_i,
  output logic [2:0]        mode_o,
  output logic [WORD_W-1:0] next_o,
  output logic [WORD_W-1:0] dest_o,
  output logic [CNT_W-1:0]  size_o,
  output logic [WORD_W-1:0] pat_lo_o,
  output logic [WORD_W-1:0] pat_hi_o,
  output logic              start_o,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] cfg_q, next_q, dest_q, size_q, plo_q, phi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      next_q <= '0;
      dest_q <= '0;
      size_q <= '0;
      plo_q  <= '0;
      phi_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        RA_CFG:  cfg_q  <= wdata_i;
        RA_NEXT: next_q <= wdata_i;
        RA_DST:  dest_q <= wdata_i;
        RA_SIZE: size_q <= wdata_i;
        RA_PLO:  plo_q  <= wdata_i;
        RA_PHI:  phi_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign start_o  = we_i && (addr_i == RA_ACT) && wdata_i[ACT_GO_BIT] && !busy_i;
  assign mode_o   = cfg_q[2:0];
  assign next_o   = next_q;
  assign dest_o   = dest_q;
  assign size_o   = size_q[CNT_W-1:0];
  assign pat_lo_o = plo_q;
  assign pat_hi_o = phi_q;

  always_comb begin
    case (addr_i)
      RA_CFG:  rdata_o = cfg_q;
      RA_ACT:  rdata_o = {26'd0, 1'b0, busy_i, 4'd0};
      RA_NEXT: rdata_o = next_q;
      RA_CUR:  rdata_o = cur_desc_i;
      RA_DST:  rdata_o = dest_q;
      RA_SIZE: rdata_o = size_q;
      RA_PLO:  rdata_o = plo_q;
      default: rdata_o = phi_q;
    endcase
  end
endmodule

// File: rtl/xdma_pick.sv
module xdma_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] below;

  for (genvar g = 0; g < N; g++) begin : g_below
    if (g == 0) begin : g_first
      assign below[g] = 1'b0;
    end else begin : g_rest
      assign below[g] = |req_i[g-1:0];
    end
  end

  assign onehot_o = req_i & ~below;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/xdma_engine.sv
module xdma_engine
  import xdma_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic [WORD_W-1:0] next_i,
  input  logic [WORD_W-1:0] dest_i,
  input  logic [CNT_W-1:0]  size_i,
  input  logic [WORD_W-1:0] pat_lo_i,
  input  logic [WORD_W-1:0] pat_hi_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic [WORD_W-1:0] cur_desc_o,
  output logic              eoc_o
);
  localparam int DESC_W  = OFF_SRC0 + N_SRC;
  localparam int FIDX_W  = $clog2(DESC_W);
  localparam int WORDS_W = CNT_W - 1;
  localparam int IDX_W   = $clog2(N_SRC);

  state_e             state_q;
  logic [2:0]         run_mode_q;
  logic [WORD_W-1:0]  base_q, cur_q, nxt_q, dst_q, acc_q;
  logic [FIDX_W-1:0]  fidx_q;
  logic               cmd_valid_q, err_q, eoc_q;
  logic [N_SRC-1:0]   cmd_en_q, mask_q, init_mask, pick_oh;
  logic [IDX_W-1:0]   pick_idx;
  logic [CNT_W-1:0]   cnt_q;
  logic [WORDS_W-1:0] widx_q, nwords_q;
  logic [WORD_W-1:0]  src_q [N_SRC];
  logic [WORD_W-1:0]  word_off, fetch_off;

  function automatic logic [WORDS_W-1:0] to_words(input logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, b} + (CNT_W+1)'(3);
    return s[CNT_W:2];
  endfunction

  xdma_pick #(.N(N_SRC), .IW(IDX_W)) u_pick (
    .req_i   (mask_q),
    .onehot_o(pick_oh),
    .idx_o   (pick_idx)
  );

  assign init_mask = (run_mode_q == MODE_XOR) ? cmd_en_q : N_SRC'(1);
  assign word_off  = {{(WORD_W-WORDS_W-2){1'b0}}, widx_q, 2'b00};
  assign fetch_off = {{(WORD_W-FIDX_W-2){1'b0}}, fidx_q, 2'b00};

  // source address capture, one register per slot
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) src_q[g] <= '0;
      else if (state_q == ST_FETCH && fidx_q == FIDX_W'(OFF_SRC0 + g)) src_q[g] <= mem_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      run_mode_q  <= '0;
      base_q      <= '0;
      cur_q       <= '0;
      nxt_q       <= '0;
      dst_q       <= '0;
      acc_q       <= '0;
      fidx_q      <= '0;
      cmd_valid_q <= 1'b0;
      cmd_en_q    <= '0;
      cnt_q       <= '0;
      err_q       <= 1'b0;
      mask_q      <= '0;
      widx_q      <= '0;
      nwords_q    <= '0;
      eoc_q       <= 1'b0;
    end else begin
      eoc_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (mode_i == MODE_FILL) begin
              base_q   <= dest_i;
              widx_q   <= '0;
              nwords_q <= to_words(size_i);
              if (to_words(size_i) == '0) eoc_q <= 1'b1;
              else state_q <= ST_FILL;
            end else if ((mode_i == MODE_XOR || mode_i == MODE_COPY) && next_i != '0) begin
              run_mode_q <= mode_i;
              base_q     <= next_i;
              cur_q      <= next_i;
              fidx_q     <= FIDX_W'(OFF_CMD);
              state_q    <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          case (int'(fidx_q))
            OFF_CMD: begin
              cmd_valid_q <= mem_rdata_i[CMD_VALID_BIT];
              cmd_en_q    <= mem_rdata_i[N_SRC-1:0];
            end
            OFF_CNT:  cnt_q <= mem_rdata_i[CNT_W-1:0];
            OFF_NEXT: nxt_q <= mem_rdata_i;
            OFF_DEST: dst_q <= mem_rdata_i;
            default: ;
          endcase
          fidx_q <= fidx_q + 1'b1;
          if (fidx_q == FIDX_W'(DESC_W - 1)) state_q <= ST_PREP;
        end
        ST_PREP: begin
          err_q    <= (cnt_q == '0);
          nwords_q <= to_words(cnt_q);
          widx_q   <= '0;
          acc_q    <= '0;
          mask_q   <= init_mask;
          state_q  <= (cnt_q == '0 || !cmd_valid_q) ? ST_STAT : ST_SRC;
        end
        ST_SRC: begin
          if (|mask_q) begin
            acc_q  <= acc_q ^ mem_rdata_i;
            mask_q <= mask_q & ~pick_oh;
          end else begin
            state_q <= ST_WR;
          end
        end
        ST_WR: begin
          widx_q <= widx_q + 1'b1;
          acc_q  <= '0;
          mask_q <= init_mask;
          state_q <= (widx_q == nwords_q - 1'b1) ? ST_STAT : ST_SRC;
        end
        ST_STAT: begin
          if (nxt_q == '0) begin
            eoc_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            base_q  <= nxt_q;
            cur_q   <= nxt_q;
            fidx_q  <= FIDX_W'(OFF_CMD);
            state_q <= ST_FETCH;
          end
        end
        ST_FILL: begin
          widx_q <= widx_q + 1'b1;
          if (widx_q == nwords_q - 1'b1) begin
            eoc_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (state_q)
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = base_q + fetch_off;
      end
      ST_SRC: begin
        mem_req_o  = |mask_q;
        mem_addr_o = src_q[pick_idx] + word_off;
      end
      ST_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = dst_q + word_off;
        mem_wdata_o = acc_q;
      end
      ST_STAT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = base_q;
        mem_wdata_o = WORD_W'(err_q);
      end
      ST_FILL: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = base_q + word_off;
        mem_wdata_o = widx_q[0] ? pat_hi_i : pat_lo_i;
      end
      default: ;
    endcase
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign cur_desc_o = cur_q;
  assign eoc_o      = eoc_q;
endmodule

// File: rtl/xdma_chain.sv
module xdma_chain
  import xdma_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              eoc_o
);
  logic              busy, start;
  logic [2:0]        mode;
  logic [WORD_W-1:0] next_ptr, fill_dst, pat_lo, pat_hi, cur_desc;
  logic [CNT_W-1:0]  fill_size;

  xdma_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .busy_i    (busy),
    .cur_desc_i(cur_desc),
    .mode_o    (mode),
    .next_o    (next_ptr),
    .dest_o    (fill_dst),
    .size_o    (fill_size),
    .pat_lo_o  (pat_lo),
    .pat_hi_o  (pat_hi),
    .start_o   (start),
    .rdata_o   (reg_rdata_o)
  );

  xdma_engine #(.N_SRC(N_SRC), .CNT_W(CNT_W)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .mode_i     (mode),
    .next_i     (next_ptr),
    .dest_i     (fill_dst),
    .size_i     (fill_size),
    .pat_lo_i   (pat_lo),
    .pat_hi_i   (pat_hi),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i),
    .busy_o     (busy),
    .cur_desc_o (cur_desc),
    .eoc_o      (eoc_o)
  );
endmodule

// File: rtl/xdma_chain_chk.sv
module xdma_chain_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic        eoc_o,
  input logic        busy,
  input logic        reg_we_i,
  input logic [2:0]  reg_addr_i,
  input logic [31:0] reg_wdata_i
);
  a_r13_we_with_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);

  a_r13_port_only_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy);

  a_r9_eoc_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> !busy);

  a_r9_eoc_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> !eoc_o);

  a_r2_active_after_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(reg_we_i && reg_addr_i == 3'd1 && reg_wdata_i[0]));
endmodule

bind xdma_chain xdma_chain_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .eoc_o      (eoc_o),
  .busy       (busy),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i)
);

// File: tb/xdma_chain_tb.sv
module xdma_chain_tb;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;
  localparam int SRC_W = 72;   // source i at word SRC_W + 8*i
  localparam int XDST_W = 140;
  localparam int FDST_W = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        eoc;
  logic [31:0] mem [256];
  int vectors = 0;
  int miscompares = 0;
  int fill_reads = 0;
  logic fill_watch = 1'b0;

  always #4 clk = ~clk;

  xdma_chain u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .eoc_o(eoc)
  );

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (fill_watch && mem_req && !mem_we) fill_reads <= fill_reads + 1;
  end

  function automatic logic [31:0] pat(input int i, input int w);
    return (32'h9E37_79B9 * 32'(i * 16 + w + 1)) ^ (32'h0101_0101 << i);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!eoc && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(req, 32'(eoc), 32'd1);
    @(negedge clk);
  endtask

  // 13-word descriptor at word wb, sources point at the pattern regions
  task automatic put_desc(input int wb, input logic [31:0] cmd, input logic [31:0] cnt,
                          input logic [31:0] nxt, input logic [31:0] dst);
    mem[wb]     = 32'h8000_0000;
    mem[wb + 1] = cmd;
    mem[wb + 2] = cnt;
    mem[wb + 3] = nxt;
    mem[wb + 4] = dst;
    for (int i = 0; i < 8; i++) mem[wb + 5 + i] = 32'((SRC_W + 8 * i) * 4);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    repeat (149000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] rd, x;
    for (int k = 0; k < 256; k++) mem[k] = '0;
    for (int i = 0; i < 8; i++)
      for (int w = 0; w < 8; w++) mem[SRC_W + 8 * i + w] = pat(i, w);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    reg_rd(3'd1, rd); chk("R2 reset activation", rd, 32'h0);
    reg_rd(3'd3, rd); chk("R10 reset current", rd, 32'h0);
    chk("R9 reset eoc", 32'(eoc), 32'h0);
    chk("R13 reset mem_req", 32'(mem_req), 32'h0);

    // R1 readback and unsupported mode
    reg_wr(3'd0, 32'h1234_5002);
    reg_rd(3'd0, rd); chk("R1 config readback", rd, 32'h1234_5002);
    put_desc(4, 32'h8000_0001, 32'd4, 32'd0, 32'(XDST_W * 4));
    mem[XDST_W] = SENT;
    reg_wr(3'd0, 32'h0000_0003);
    reg_wr(3'd2, 32'd16);
    reg_wr(3'd1, 32'd1);
    reg_rd(3'd1, rd); chk("R1 bad mode stays idle", rd, 32'h0);
    repeat (20) @(negedge clk);
    chk("R1 bad mode no status write", mem[4], 32'h8000_0000);
    chk("R1 bad mode no data write", mem[XDST_W], SENT);

    // R3 R4 R6 R7: sweep every source-enable mask
    reg_wr(3'd0, 32'h0000_0001);
    for (int m = 0; m < 256; m++) begin
      int cnt, nw;
      cnt = 1 + (m % 12);
      nw = (cnt + 3) / 4;
      for (int w = 0; w < 4; w++) mem[XDST_W + w] = SENT;
      put_desc(4, 32'h8000_0000 | 32'(m), 32'(cnt), 32'd0, 32'(XDST_W * 4));
      reg_wr(3'd1, 32'd1);
      wait_done("R9 xor sweep end pulse");
      for (int w = 0; w < 4; w++) begin
        x = '0;
        for (int i = 0; i < 8; i++) if (m[i]) x = x ^ pat(i, w);
        if (w < nw) chk("R4 xor word", mem[XDST_W + w], x);
        else chk("R6 word past count untouched", mem[XDST_W + w], SENT);
      end
      chk("R7 status returned", mem[4], 32'h0);
    end

    // chain: copy with enables off, invalid descriptor, zero count
    reg_wr(3'd0, 32'h0000_0002);
    for (int w = 144; w < 160; w++) mem[w] = SENT;
    put_desc(4, 32'h8000_00FE, 32'd8, 32'd80, 32'd576);
    put_desc(20, 32'h0000_00FF, 32'd8, 32'd144, 32'd592);
    put_desc(36, 32'h8000_0001, 32'd0, 32'd0, 32'd608);
    reg_wr(3'd2, 32'd16);
    reg_wr(3'd1, 32'd1);
    reg_rd(3'd1, rd); chk("R2 activation reads active", rd, 32'h0000_0010);
    wait_done("R9 chain end pulse");
    reg_rd(3'd1, rd); chk("R2 activation reads idle", rd, 32'h0);
    chk("R5 copy word 0", mem[144], pat(0, 0));
    chk("R5 copy word 1", mem[145], pat(0, 1));
    chk("R6 copy past count", mem[146], SENT);
    chk("R8 invalid desc no write", mem[148], SENT);
    chk("R8 invalid desc status", mem[20], 32'h0);
    chk("R7 zero count no write", mem[152], SENT);
    chk("R7 zero count status", mem[36], 32'h1);
    chk("R9 first desc status", mem[4], 32'h0);
    reg_rd(3'd3, rd); chk("R10 current is tail", rd, 32'd144);
    chk("R13 port quiet when idle", 32'(mem_req), 32'h0);

    // R11: link a new tail while idle
    put_desc(52, 32'h8000_0000, 32'd4, 32'd0, 32'd624);
    mem[36 + 3] = 32'd208;
    repeat (40) @(negedge clk);
    chk("R11 relinked not processed", mem[156], SENT);
    chk("R11 relinked status kept", mem[52], 32'h8000_0000);
    reg_rd(3'd3, rd); chk("R11 current unchanged", rd, 32'd144);
    reg_wr(3'd2, 32'd208);
    reg_wr(3'd1, 32'd1);
    wait_done("R11 restart end pulse");
    chk("R11 restart copies", mem[156], pat(0, 0));
    chk("R11 restart status", mem[52], 32'h0);
    reg_rd(3'd3, rd); chk("R10 current after restart", rd, 32'd208);

    // R12: fill sweep
    reg_wr(3'd0, 32'h0000_0004);
    reg_wr(3'd4, 32'(FDST_W * 4));
    for (int s = 0; s < 10; s++) begin
      int nw;
      logic [31:0] lo, hi;
      nw = (s + 3) / 4;
      lo = 32'hA5A5_0000 | 32'(s);
      hi = 32'h5A5A_0000 | 32'(s);
      for (int k = 0; k < 5; k++) mem[FDST_W + k] = SENT;
      reg_wr(3'd5, 32'(s));
      reg_wr(3'd6, lo);
      reg_wr(3'd7, hi);
      fill_watch = 1'b1;
      reg_wr(3'd1, 32'd1);
      wait_done("R12 fill end pulse");
      fill_watch = 1'b0;
      for (int k = 0; k < 5; k++) begin
        if (k < nw) chk("R12 fill word", mem[FDST_W + k], (k % 2 == 0) ? lo : hi);
        else chk("R12 fill past length", mem[FDST_W + k], SENT);
      end
    end
    chk("R12 fill reads no descriptor", 32'(fill_reads), 32'h0);
    chk("R12 fill leaves descriptor", mem[52], 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule